// File: doc/BRIEF.md
# Configuration Space Access Port

This block sits between a CPU register interface and a downstream configuration bus model. Software first writes a target address into an address register, then reads or writes a data register. Each data access becomes one 32-bit configuration request on the downstream side. A request carries the stored address, the write data, a direction flag and a one-cycle strobe. A read completes only after the downstream side answers with an acknowledge and a data word.

A command register holds a byte-order control bit. When that bit is clear and the stored address points to a non-zero bus or device, the data word is byte-reversed in both directions. Bit 31 of the address register gates all data accesses. With bit 31 clear, a data write is dropped, and a data read returns the all-ones word without touching the bus.

The CPU side selects a register with a 2-bit code: 0 is the address register, 1 is the data register, 2 is the command register, and 3 is unused.

Top module: `cfg_port`

## Requirements
- R1: A write with select 0 stores the write data ANDed with 0x80FFFFFC. A read with select 0 returns that stored value, with `cpu_rvalid` high in the cycle after the read request. The stored value is 0 after reset.
- R2: A write with select 2 stores the write data ANDed with 0x0401FC0F. A read with select 2 returns that stored value. The stored value is 0x00010001 after reset.
- R3: A write with select 1 while address bit 31 is set raises `bus_strobe` for exactly one cycle, starting the cycle after the write. During that cycle `bus_write` is 1 and `bus_addr` equals the stored address.
- R4: A write with select 1 while address bit 31 is clear issues no strobe.
- R5: A read with select 1 while address bit 31 is clear issues no strobe. It returns 0xFFFFFFFF with `cpu_rvalid` high in the next cycle.
- R6: A read with select 1 while address bit 31 is set raises a one-cycle strobe with `bus_write` = 0. The block then waits for `bus_ack`. `cpu_rvalid` is high in the cycle after the acknowledge, with the returned word.
- R7: When command bit 0 is clear and the stored address ANDed with 0x00FFF800 is non-zero, the block reverses the four bytes of the data word, on writes toward the bus and on reads toward the CPU. Byte 3 trades places with byte 0, and byte 2 with byte 1.
- R8: When command bit 0 is set, or the address field ANDed with 0x00FFF800 is zero, data passes through unchanged.
- R9: While a read waits for its acknowledge, CPU writes and reads are ignored. The registers keep their values and no further strobe is issued.
- R10: A read with select 3 returns 0 with `cpu_rvalid` in the next cycle, and a write with select 3 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_sel | input | 2 | Register select (0 address, 1 data, 2 command, 3 unused) |
| cpu_wr | input | 1 | Write request |
| cpu_rd | input | 1 | Read request |
| cpu_wdata | input | 32 | Write data |
| cpu_rdata | output | 32 | Read data, valid with cpu_rvalid |
| cpu_rvalid | output | 1 | One-cycle read completion |
| bus_strobe | output | 1 | One-cycle configuration request |
| bus_write | output | 1 | Request direction, 1 for write |
| bus_addr | output | 32 | Configuration address of the request |
| bus_wdata | output | 32 | Write data of the request, after any byte reversal |
| bus_ack | input | 1 | Read acknowledge from the downstream side |
| bus_rdata | input | 32 | Read data, valid with bus_ack |

## Verification
Every result is registered, so each output is due exactly one clock edge after the input that causes it:
- `bus_strobe` follows a data access by one edge.
- `cpu_rvalid` follows a register read, an aborted read or the acknowledge by one edge.

The bench drives inputs on the falling edge and samples on the falling edge that follows the rising edge in question. Each check therefore looks at the exact cycle in which the result is due. For the strobe, the bench also checks the cycle after, where it must be low again. For reads that stall, the bench holds the acknowledge back for several cycles and confirms that no completion appears early.

// File: rtl/cfg_port_pkg.sv
package cfg_port_pkg;
    localparam int unsigned CFG_W = 32;
    localparam int unsigned SEL_W = 2;

    localparam logic [CFG_W-1:0] ADDR_KEEP   = 32'h80FF_FFFC;
    localparam logic [CFG_W-1:0] CMD_KEEP    = 32'h0401_FC0F;
    localparam logic [CFG_W-1:0] CMD_RESET   = 32'h0001_0001;
    localparam logic [CFG_W-1:0] ROUTE_FIELD = 32'h00FF_F800;
    localparam logic [CFG_W-1:0] ABORT_WORD  = 32'hFFFF_FFFF;

    typedef enum logic [SEL_W-1:0] {
        SEL_ADDR = 2'd0,
        SEL_DATA = 2'd1,
        SEL_CMD  = 2'd2,
        SEL_NONE = 2'd3
    } sel_e;

    typedef enum logic {
        PH_IDLE = 1'b0,
        PH_WAIT = 1'b1
    } phase_e;

    typedef struct packed {
        phase_e           phase;
        logic [CFG_W-1:0] addr;
        logic [CFG_W-1:0] cmd;
        logic             strobe;
        logic             write;
        logic [CFG_W-1:0] wdata;
        logic [CFG_W-1:0] rdata;
        logic             rvalid;
    } port_state_t;
endpackage

// File: rtl/cfg_port_swap.sv
module cfg_port_swap #(
    parameter int unsigned LANES = 4
) (
    input  logic               en,
    input  logic [LANES*8-1:0] din,
    output logic [LANES*8-1:0] dout
);
    logic [LANES*8-1:0] reversed;

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign reversed[i*8 +: 8] = din[(LANES-1-i)*8 +: 8];
    end

    assign dout = en ? reversed : din;
endmodule

// File: rtl/cfg_port_route.sv
module cfg_port_route
    import cfg_port_pkg::*;
(
    input  logic [CFG_W-1:0] addr,
    input  logic [CFG_W-1:0] cmd,
    output logic             enable,
    output logic             swap
);
    assign enable = addr[CFG_W-1];
    assign swap   = !cmd[0] && (|(addr & ROUTE_FIELD));
endmodule

// File: rtl/cfg_port.sv
module cfg_port
    import cfg_port_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] cpu_sel,
    input  logic             cpu_wr,
    input  logic             cpu_rd,
    input  logic [CFG_W-1:0] cpu_wdata,
    output logic [CFG_W-1:0] cpu_rdata,
    output logic             cpu_rvalid,
    output logic             bus_strobe,
    output logic             bus_write,
    output logic [CFG_W-1:0] bus_addr,
    output logic [CFG_W-1:0] bus_wdata,
    input  logic             bus_ack,
    input  logic [CFG_W-1:0] bus_rdata
);
    localparam int unsigned LANES = CFG_W / 8;

    port_state_t st_d, st_q;
    logic        route_en, route_swap;
    logic [CFG_W-1:0] wr_word, rd_word;

    cfg_port_route u_route (
        .addr   (st_q.addr),
        .cmd    (st_q.cmd),
        .enable (route_en),
        .swap   (route_swap)
    );

    cfg_port_swap #(.LANES(LANES)) u_swap_wr (
        .en   (route_swap),
        .din  (cpu_wdata),
        .dout (wr_word)
    );

    cfg_port_swap #(.LANES(LANES)) u_swap_rd (
        .en   (route_swap),
        .din  (bus_rdata),
        .dout (rd_word)
    );

    always_comb begin
        st_d        = st_q;
        st_d.strobe = 1'b0;
        st_d.rvalid = 1'b0;
        unique case (st_q.phase)
            PH_IDLE: begin
                if (cpu_wr) begin
                    case (sel_e'(cpu_sel))
                        SEL_ADDR: st_d.addr = cpu_wdata & ADDR_KEEP;
                        SEL_CMD:  st_d.cmd  = cpu_wdata & CMD_KEEP;
                        SEL_DATA: begin
                            if (route_en) begin
                                st_d.strobe = 1'b1;
                                st_d.write  = 1'b1;
                                st_d.wdata  = wr_word;
                            end
                        end
                        default: ;
                    endcase
                end else if (cpu_rd) begin
                    st_d.rvalid = 1'b1;
                    case (sel_e'(cpu_sel))
                        SEL_ADDR: st_d.rdata = st_q.addr;
                        SEL_CMD:  st_d.rdata = st_q.cmd;
                        SEL_DATA: begin
                            if (route_en) begin
                                st_d.rvalid = 1'b0;
                                st_d.strobe = 1'b1;
                                st_d.write  = 1'b0;
                                st_d.phase  = PH_WAIT;
                            end else begin
                                st_d.rdata = ABORT_WORD;
                            end
                        end
                        default: st_d.rdata = '0;
                    endcase
                end
            end
            PH_WAIT: begin
                if (bus_ack) begin
                    st_d.rvalid = 1'b1;
                    st_d.rdata  = rd_word;
                    st_d.phase  = PH_IDLE;
                end
            end
            default: st_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q        <= '0;
            st_q.phase  <= PH_IDLE;
            st_q.cmd    <= CMD_RESET;
        end else begin
            st_q <= st_d;
        end
    end

    assign cpu_rdata  = st_q.rdata;
    assign cpu_rvalid = st_q.rvalid;
    assign bus_strobe = st_q.strobe;
    assign bus_write  = st_q.write;
    assign bus_addr   = st_q.addr;
    assign bus_wdata  = st_q.wdata;

    // R1: stored address never holds a masked-off bit
    assert_addr_masked_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr & ~ADDR_KEEP) == '0);

    // R3: a request strobe never lasts two cycles
    assert_strobe_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
        bus_strobe |=> !bus_strobe);

    // R4: a data write with the enable clear issues nothing
    assert_write_gated_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.phase == PH_IDLE && cpu_wr && cpu_sel == SEL_DATA && !bus_addr[CFG_W-1])
        |=> !bus_strobe);

    // R5: a data read with the enable clear completes at once with all ones
    assert_read_abort_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.phase == PH_IDLE && !cpu_wr && cpu_rd && cpu_sel == SEL_DATA
         && !bus_addr[CFG_W-1])
        |=> (cpu_rvalid && !bus_strobe && cpu_rdata == ABORT_WORD));

    // R6: an acknowledge while waiting completes the read next cycle
    assert_ack_completes_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.phase == PH_WAIT && bus_ack) |=> cpu_rvalid);

    // R9: the address register is frozen while a read waits
    assert_wait_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.phase == PH_WAIT) |=> $stable(bus_addr));
endmodule

// File: tb/sim_cfg_port.sv
module sim_cfg_port;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  cpu_sel = '0;
    logic        cpu_wr = 1'b0, cpu_rd = 1'b0;
    logic [31:0] cpu_wdata = '0;
    logic [31:0] cpu_rdata;
    logic        cpu_rvalid, bus_strobe, bus_write;
    logic [31:0] bus_addr, bus_wdata;
    logic        bus_ack = 1'b0;
    logic [31:0] bus_rdata = '0;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    cfg_port u0 (
        .clk(clk), .rst_n(rst_n), .cpu_sel(cpu_sel), .cpu_wr(cpu_wr), .cpu_rd(cpu_rd),
        .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .cpu_rvalid(cpu_rvalid),
        .bus_strobe(bus_strobe), .bus_write(bus_write), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_ack(bus_ack), .bus_rdata(bus_rdata)
    );

    // columns: command, address, cpu data, word seen on the bus / returned to cpu
    localparam logic [127:0] VEC [6] = '{
        {32'h0001_0001, 32'h8000_0800, 32'h1122_3344, 32'h1122_3344}, // R8 order bit set
        {32'h0000_0000, 32'h8000_0800, 32'h1122_3344, 32'h4433_2211}, // R7 device 1
        {32'h0000_0000, 32'h8000_0004, 32'hA1B2_C3D4, 32'hA1B2_C3D4}, // R8 bus 0 device 0
        {32'h0000_0000, 32'h8001_0000, 32'hA1B2_C3D4, 32'hD4C3_B2A1}, // R7 bus 1
        {32'h0000_0000, 32'h8000_07FC, 32'hDEAD_BEEF, 32'hDEAD_BEEF}, // R8 function bits only
        {32'h0401_FC0E, 32'h80FF_F800, 32'h0102_0304, 32'h0403_0201}  // R7 all route bits
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] s, input logic [31:0] d);
        cpu_sel = s; cpu_wdata = d; cpu_wr = 1'b1;
        @(posedge clk); @(negedge clk);
        cpu_wr = 1'b0;
    endtask

    task automatic rd_reg(input logic [1:0] s, output logic [31:0] d, output logic v);
        cpu_sel = s; cpu_rd = 1'b1;
        @(posedge clk); @(negedge clk);
        cpu_rd = 1'b0;
        d = cpu_rdata; v = cpu_rvalid;
    endtask

    // enabled data read: check request, delay the ack, return resp
    task automatic rd_bus(input int delay, input logic [31:0] resp, input logic [31:0] addr_exp,
                          output logic [31:0] d);
        cpu_sel = 2'd1; cpu_rd = 1'b1;
        @(posedge clk); @(negedge clk);
        cpu_rd = 1'b0;
        chk("R6 read strobe", {31'd0, bus_strobe}, 32'd1);
        chk("R6 read direction", {31'd0, bus_write}, 32'd0);
        chk("R6 read address", bus_addr, addr_exp);
        for (int i = 0; i < delay; i++) begin
            @(posedge clk); @(negedge clk);
            chk("R6 no early completion", {30'd0, bus_strobe, cpu_rvalid}, 32'd0);
        end
        bus_ack = 1'b1; bus_rdata = resp;
        @(posedge clk); @(negedge clk);
        bus_ack = 1'b0;
        chk("R6 completion", {31'd0, cpu_rvalid}, 32'd1);
        d = cpu_rdata;
    endtask

    initial begin
        #400000;
        errors++;
        $display("FAIL watchdog actual=%08h expected=%08h", 32'd1, 32'd0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] d;
        logic v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // reset state
        rd_reg(2'd0, d, v);
        chk("R1 reset address", d, 32'h0);
        chk("R1 read valid", {31'd0, v}, 32'd1);
        rd_reg(2'd2, d, v);
        chk("R2 reset command", d, 32'h0001_0001);

        // table walk
        for (int k = 0; k < 6; k++) begin
            logic [31:0] c, a, x, e;
            {c, a, x, e} = VEC[k];
            wr(2'd2, c);
            wr(2'd0, a);
            wr(2'd1, x);
            chk("R3 write strobe", {31'd0, bus_strobe}, 32'd1);
            chk("R3 write direction", {31'd0, bus_write}, 32'd1);
            chk("R3 write address", bus_addr, a);
            chk("R7 R8 write word", bus_wdata, e);
            @(posedge clk); @(negedge clk);
            chk("R3 strobe one cycle", {31'd0, bus_strobe}, 32'd0);
            rd_bus(k % 3, x, a, d);
            chk("R7 R8 read word", d, e);
        end

        // masking
        wr(2'd0, 32'hFFFF_FFFF);
        rd_reg(2'd0, d, v);
        chk("R1 address mask", d, 32'h80FF_FFFC);
        wr(2'd2, 32'hFFFF_FFFF);
        rd_reg(2'd2, d, v);
        chk("R2 command mask", d, 32'h0401_FC0F);

        // enable clear
        wr(2'd0, 32'h0000_0800);
        wr(2'd1, 32'h5555_AAAA);
        chk("R4 gated write", {31'd0, bus_strobe}, 32'd0);
        rd_reg(2'd1, d, v);
        chk("R5 abort valid", {31'd0, v}, 32'd1);
        chk("R5 abort no strobe", {31'd0, bus_strobe}, 32'd0);
        chk("R5 abort word", d, 32'hFFFF_FFFF);

        // unused select
        wr(2'd3, 32'h1234_5678);
        rd_reg(2'd3, d, v);
        chk("R10 unused read", d, 32'h0);
        rd_reg(2'd0, d, v);
        chk("R10 unused write no effect", d, 32'h0000_0800);

        // accesses during a waiting read
        wr(2'd2, 32'h0001_0001);
        wr(2'd0, 32'h8000_1000);
        cpu_sel = 2'd1; cpu_rd = 1'b1;
        @(posedge clk); @(negedge clk);
        cpu_rd = 1'b0;
        chk("R9 read issued", {31'd0, bus_strobe}, 32'd1);
        wr(2'd0, 32'h8000_2000);
        chk("R9 no strobe", {31'd0, bus_strobe}, 32'd0);
        wr(2'd1, 32'h9999_9999);
        chk("R9 no data strobe", {31'd0, bus_strobe}, 32'd0);
        wr(2'd2, 32'h0000_0000);
        bus_ack = 1'b1; bus_rdata = 32'hCAFE_F00D;
        @(posedge clk); @(negedge clk);
        bus_ack = 1'b0;
        chk("R9 read word", cpu_rdata, 32'hCAFE_F00D);
        rd_reg(2'd0, d, v);
        chk("R9 address kept", d, 32'h8000_1000);
        rd_reg(2'd2, d, v);
        chk("R9 command kept", d, 32'h0001_0001);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule